// File: doc/BRIEF.md
# Running-Priority Register Read Resolver

This combinational block decides what happens when software reads the running-priority system register of an interrupt controller CPU interface. It looks at the current exception level, at which optional features are present, at the per-level system-register enable bits, at the hypervisor trap and override controls, and at the secure-monitor interrupt routing bits. From these it picks exactly one outcome: deliver the physical register, deliver the virtual copy, trap to EL1, EL2 or EL3, or raise an undefined-instruction exception.

Each exception level walks its own strictly ordered chain of conditions, and the first condition that holds wins. A trap outcome always comes with exception class 0x18 for the syndrome. The block only answers requests whose system-register encoding selects this register. It does not produce register data or enter the exception.

Top module: `rpri_access_resolver`

## Requirements
- R1: The block handles a request only when `req_valid` is 1 and `req_enc` equals 16'hC65B, which is {op0=2'b11, op1=3'b000, CRn=4'b1100, CRm=4'b1011, op2=3'b011} packed from bit 15 down to bit 0. For any other request, `verdict` and `trap_class` are all zero.
- R2: For a handled request, exactly one bit of `verdict` is set. The bit meanings are [5] undefined, [4] trap to EL1, [3] trap to EL2, [2] trap to EL3, [1] read virtual copy, [0] read physical register.
- R3: If `has_ctrl` or `has_aa64` is 0, a handled request gives the undefined outcome at every level.
- R4: A handled request with `cur_level` = 0 gives the undefined outcome.
- R5: At `cur_level` = 1 the first rules apply in this order. Undefined when `has_el3`, `dbg_prio_undef`, `mon_irq_route` and `mon_fiq_route` are all 1. Otherwise, trap to EL1 when `sre_l1` is 0. Otherwise, trap to EL2 when `el2_on` and `hyp_trap_common` are both 1.
- R6: At `cur_level` = 1, the remaining rules apply in this order. Read virtual when `el2_on` is 1 and `hyp_fiq_ovr` or `hyp_irq_ovr` is 1. Otherwise, when `has_el3` and both routing bits are 1, the outcome is undefined if `dbg_undef` is 1 and trap to EL3 if it is 0. Otherwise, read physical.
- R7: At `cur_level` = 2 the rules apply in this order: the debug-priority undefined rule of R5, then trap to EL2 when `sre_l2` is 0, then the monitor routing rule of R6, then read physical. The virtual and EL1 outcomes never occur at this level.
- R8: At `cur_level` = 3 the outcome is trap to EL3 when `sre_l3` is 0 and read physical otherwise. No hypervisor, routing or debug input has an effect at this level.
- R9: `trap_class` is 6'h18 whenever a trap bit of `verdict` is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | A system-register read request is present |
| req_enc | input | 16 | Packed register encoding {op0, op1, CRn, CRm, op2} |
| cur_level | input | 2 | Exception level of the requester, 0 to 3 |
| has_ctrl | input | 1 | Interrupt controller system interface is implemented |
| has_aa64 | input | 1 | 64-bit execution state is implemented |
| has_el3 | input | 1 | EL3 is implemented |
| el2_on | input | 1 | EL2 is enabled for the current security state |
| sre_l1 | input | 1 | System-register interface enable for EL1 |
| sre_l2 | input | 1 | System-register interface enable for EL2 |
| sre_l3 | input | 1 | System-register interface enable for EL3 |
| hyp_trap_common | input | 1 | Hypervisor trap of common controller registers |
| hyp_fiq_ovr | input | 1 | Hypervisor FIQ routing override |
| hyp_irq_ovr | input | 1 | Hypervisor IRQ routing override |
| mon_irq_route | input | 1 | Monitor routes IRQ to EL3 |
| mon_fiq_route | input | 1 | Monitor routes FIQ to EL3 |
| dbg_prio_undef | input | 1 | Debug condition that makes the access undefined ahead of all traps |
| dbg_undef | input | 1 | Debug condition that turns an EL3 routing trap into undefined |
| verdict | output | 6 | One-hot outcome {undef, trap_l1, trap_l2, trap_l3, rd_virt, rd_phys} |
| trap_class | output | 6 | Syndrome exception class for a trap, else 0 |

## Verification
Each level is swept over all 16384 settings of the fourteen control inputs. The expected outcome for every setting comes from a first-match rule list kept in the bench, so each input pattern shows whether a higher-ranked rule correctly masks a lower one. For example, an enable bit at 0 together with hypervisor traps set shows whether the EL1 trap outranks the EL2 trap. Routing bits with `dbg_undef` on and off show the undefined-versus-EL3 split. Separate patterns flip each encoding bit and drop `req_valid` to confirm that an unmatched request produces no outcome at all.

// File: rtl/rpri_pkg.sv
package rpri_pkg;

  typedef enum logic [1:0] {
    LVL_APP = 2'd0,
    LVL_OS  = 2'd1,
    LVL_HYP = 2'd2,
    LVL_MON = 2'd3
  } level_e;

  typedef struct packed {
    logic undef;
    logic trap_l1;
    logic trap_l2;
    logic trap_l3;
    logic rd_virt;
    logic rd_phys;
  } verdict_t;

  localparam int VERDICT_W = $bits(verdict_t);

  localparam verdict_t V_NONE  = 6'b000000;
  localparam verdict_t V_UNDEF = 6'b100000;
  localparam verdict_t V_TL1   = 6'b010000;
  localparam verdict_t V_TL2   = 6'b001000;
  localparam verdict_t V_TL3   = 6'b000100;
  localparam verdict_t V_VIRT  = 6'b000010;
  localparam verdict_t V_PHYS  = 6'b000001;

  // Both interrupt kinds routed to the monitor level.
  function automatic logic both_to_mon(input logic irq_r, input logic fiq_r);
    return irq_r & fiq_r;
  endfunction

  // Debug condition that outranks every trap.
  function automatic logic early_undef(input logic el3_p, input logic dbgp,
                                       input logic irq_r, input logic fiq_r);
    return el3_p & dbgp & both_to_mon(irq_r, fiq_r);
  endfunction

  // Result of the monitor routing rule once it applies.
  function automatic verdict_t mon_route_result(input logic dbg_u);
    return dbg_u ? V_UNDEF : V_TL3;
  endfunction

  function automatic logic is_trap(input verdict_t v);
    return v.trap_l1 | v.trap_l2 | v.trap_l3;
  endfunction

endpackage

// File: rtl/rpri_enc_match.sv
module rpri_enc_match #(
  parameter int              ENC_W     = 16,
  parameter logic [ENC_W-1:0] ENC_MATCH = 16'hC65B
) (
  input  logic             valid,
  input  logic [ENC_W-1:0] enc,
  output logic             hit
);
  assign hit = valid && (enc == ENC_MATCH);
endmodule

// File: rtl/rpri_os_chain.sv
module rpri_os_chain
  import rpri_pkg::*;
(
  input  logic     has_el3,
  input  logic     el2_on,
  input  logic     sre_l1,
  input  logic     hyp_trap_common,
  input  logic     hyp_fiq_ovr,
  input  logic     hyp_irq_ovr,
  input  logic     mon_irq_route,
  input  logic     mon_fiq_route,
  input  logic     dbg_prio_undef,
  input  logic     dbg_undef,
  output verdict_t v
);
  always_comb begin
    if (early_undef(has_el3, dbg_prio_undef, mon_irq_route, mon_fiq_route))
      v = V_UNDEF;
    else if (!sre_l1)
      v = V_TL1;
    else if (el2_on && hyp_trap_common)
      v = V_TL2;
    else if (el2_on && (hyp_fiq_ovr || hyp_irq_ovr))
      v = V_VIRT;
    else if (has_el3 && both_to_mon(mon_irq_route, mon_fiq_route))
      v = mon_route_result(dbg_undef);
    else
      v = V_PHYS;
  end
endmodule

// File: rtl/rpri_hyp_chain.sv
module rpri_hyp_chain
  import rpri_pkg::*;
(
  input  logic     has_el3,
  input  logic     sre_l2,
  input  logic     mon_irq_route,
  input  logic     mon_fiq_route,
  input  logic     dbg_prio_undef,
  input  logic     dbg_undef,
  output verdict_t v
);
  always_comb begin
    if (early_undef(has_el3, dbg_prio_undef, mon_irq_route, mon_fiq_route))
      v = V_UNDEF;
    else if (!sre_l2)
      v = V_TL2;
    else if (has_el3 && both_to_mon(mon_irq_route, mon_fiq_route))
      v = mon_route_result(dbg_undef);
    else
      v = V_PHYS;
  end
endmodule

// File: rtl/rpri_access_resolver.sv
module rpri_access_resolver
  import rpri_pkg::*;
#(
  parameter int                 ENC_W      = 16,
  parameter logic [ENC_W-1:0]   ENC_MATCH  = 16'hC65B,
  parameter int                 CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic               req_valid,
  input  logic [ENC_W-1:0]   req_enc,
  input  logic [1:0]         cur_level,
  input  logic               has_ctrl,
  input  logic               has_aa64,
  input  logic               has_el3,
  input  logic               el2_on,
  input  logic               sre_l1,
  input  logic               sre_l2,
  input  logic               sre_l3,
  input  logic               hyp_trap_common,
  input  logic               hyp_fiq_ovr,
  input  logic               hyp_irq_ovr,
  input  logic               mon_irq_route,
  input  logic               mon_fiq_route,
  input  logic               dbg_prio_undef,
  input  logic               dbg_undef,
  output logic [VERDICT_W-1:0] verdict,
  output logic [CLASS_W-1:0] trap_class
);
  logic     enc_hit;
  logic     feat_ok;
  level_e   lvl;
  verdict_t v_os, v_hyp, v_mon, v_pick, v_out;

  rpri_enc_match #(.ENC_W(ENC_W), .ENC_MATCH(ENC_MATCH)) enc_i (
    .valid (req_valid),
    .enc   (req_enc),
    .hit   (enc_hit)
  );

  rpri_os_chain os_i (
    .has_el3         (has_el3),
    .el2_on          (el2_on),
    .sre_l1          (sre_l1),
    .hyp_trap_common (hyp_trap_common),
    .hyp_fiq_ovr     (hyp_fiq_ovr),
    .hyp_irq_ovr     (hyp_irq_ovr),
    .mon_irq_route   (mon_irq_route),
    .mon_fiq_route   (mon_fiq_route),
    .dbg_prio_undef  (dbg_prio_undef),
    .dbg_undef       (dbg_undef),
    .v               (v_os)
  );

  rpri_hyp_chain hyp_i (
    .has_el3        (has_el3),
    .sre_l2         (sre_l2),
    .mon_irq_route  (mon_irq_route),
    .mon_fiq_route  (mon_fiq_route),
    .dbg_prio_undef (dbg_prio_undef),
    .dbg_undef      (dbg_undef),
    .v              (v_hyp)
  );

  // The monitor level has a single enable check.
  assign v_mon   = sre_l3 ? V_PHYS : V_TL3;
  assign feat_ok = has_ctrl & has_aa64;
  assign lvl     = level_e'(cur_level);

  always_comb begin
    unique case (lvl)
      LVL_OS:  v_pick = v_os;
      LVL_HYP: v_pick = v_hyp;
      LVL_MON: v_pick = v_mon;
      default: v_pick = V_UNDEF;
    endcase
  end

  always_comb begin
    if (!enc_hit)      v_out = V_NONE;
    else if (!feat_ok) v_out = V_UNDEF;
    else               v_out = v_pick;
  end

  assign verdict    = v_out;
  assign trap_class = is_trap(v_out) ? TRAP_CLASS : '0;
endmodule

// File: rtl/rpri_resolver_chk.sv
module rpri_resolver_chk #(
  parameter int                 ENC_W      = 16,
  parameter logic [ENC_W-1:0]   ENC_MATCH  = 16'hC65B,
  parameter int                 CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
  input logic               req_valid,
  input logic [ENC_W-1:0]   req_enc,
  input logic [1:0]         cur_level,
  input logic               has_ctrl,
  input logic               has_aa64,
  input logic               el2_on,
  input logic               sre_l3,
  input logic [5:0]         verdict,
  input logic [CLASS_W-1:0] trap_class
);
  logic req_hit;
  assign req_hit = req_valid && (req_enc == ENC_MATCH);

  always_comb begin
    // R1
    no_stray_outcome_chk: assert (req_hit || (verdict == '0 && trap_class == '0))
      else $error("outcome produced for an unhandled request");
    // R2
    one_outcome_chk: assert (!req_hit || $countones(verdict) == 1)
      else $error("handled request has %0d outcome bits", $countones(verdict));
    // R3
    feature_undef_chk: assert (!req_hit || (has_ctrl && has_aa64) || verdict == 6'b100000)
      else $error("missing feature did not give undefined");
    // R4
    app_undef_chk: assert (!req_hit || cur_level != 2'd0 || verdict == 6'b100000)
      else $error("level 0 access did not give undefined");
    // R6
    virt_only_os_chk: assert (!verdict[1] || (cur_level == 2'd1 && el2_on))
      else $error("virtual read outside level 1 with EL2 enabled");
    // R7
    hyp_no_low_chk: assert (!(req_hit && cur_level == 2'd2) || (!verdict[4] && !verdict[1]))
      else $error("level 2 produced an EL1 trap or virtual read");
    // R8
    mon_enable_chk: assert (!(req_hit && has_ctrl && has_aa64 && cur_level == 2'd3)
                            || verdict == (sre_l3 ? 6'b000001 : 6'b000100))
      else $error("level 3 outcome does not follow its enable");
    // R9
    trap_class_chk: assert (trap_class == ((|verdict[4:2]) ? TRAP_CLASS : '0))
      else $error("trap class mismatch");
  end
endmodule

bind rpri_access_resolver rpri_resolver_chk #(
  .ENC_W(ENC_W), .ENC_MATCH(ENC_MATCH), .CLASS_W(CLASS_W), .TRAP_CLASS(TRAP_CLASS)
) chk_i (
  .req_valid  (req_valid),
  .req_enc    (req_enc),
  .cur_level  (cur_level),
  .has_ctrl   (has_ctrl),
  .has_aa64   (has_aa64),
  .el2_on     (el2_on),
  .sre_l3     (sre_l3),
  .verdict    (verdict),
  .trap_class (trap_class)
);

// File: tb/rpri_access_resolver_tb_top.sv
`timescale 1ns/1ps
module rpri_access_resolver_tb_top;
  localparam logic [15:0] GOOD_ENC = 16'hC65B;
  localparam logic [5:0] E_UNDEF = 6'b100000, E_T1 = 6'b010000, E_T2 = 6'b001000,
                         E_T3 = 6'b000100, E_VIRT = 6'b000010, E_PHYS = 6'b000001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid;
  logic [15:0] req_enc;
  logic [1:0]  cur_level;
  // ctl bits: 0 ctrl,1 aa64,2 el3,3 el2on,4 sre1,5 sre2,6 sre3,7 tc,
  // 8 fiq ovr,9 irq ovr,10 mon irq,11 mon fiq,12 dbg prio,13 dbg undef
  logic [13:0] ctl;
  logic [5:0]  verdict;
  logic [5:0]  trap_class;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cycles = 0;

  rpri_access_resolver dut_i (
    .req_valid       (req_valid),
    .req_enc         (req_enc),
    .cur_level       (cur_level),
    .has_ctrl        (ctl[0]),
    .has_aa64        (ctl[1]),
    .has_el3         (ctl[2]),
    .el2_on          (ctl[3]),
    .sre_l1          (ctl[4]),
    .sre_l2          (ctl[5]),
    .sre_l3          (ctl[6]),
    .hyp_trap_common (ctl[7]),
    .hyp_fiq_ovr     (ctl[8]),
    .hyp_irq_ovr     (ctl[9]),
    .mon_irq_route   (ctl[10]),
    .mon_fiq_route   (ctl[11]),
    .dbg_prio_undef  (ctl[12]),
    .dbg_undef       (ctl[13]),
    .verdict         (verdict),
    .trap_class      (trap_class)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual verdict=%b class=%h expected verdict=%b class=%h",
               tag, act[11:6], act[5:0], exp[11:6], exp[5:0]);
    end
  endtask

  // First-match rule list per level, written as an ordered table walk.
  task automatic reference(input logic [1:0] lv, input logic [13:0] c,
                           output logic [5:0] e, output string tag);
    logic route_both, early;
    route_both = c[10] & c[11];
    early      = c[2] & c[12] & route_both;
    e = 6'b0; tag = "";
    if (!(c[0] && c[1]))      begin e = E_UNDEF; tag = "R3"; end
    else if (lv == 2'd0)      begin e = E_UNDEF; tag = "R4"; end
    else if (lv == 2'd3)      begin e = c[6] ? E_PHYS : E_T3; tag = "R8"; end
    else if (early)           begin e = E_UNDEF; tag = (lv == 2'd1) ? "R5" : "R7"; end
    else if (lv == 2'd1) begin
      if (!c[4])                  begin e = E_T1; tag = "R5"; end
      else if (c[3] && c[7])      begin e = E_T2; tag = "R5"; end
      else if (c[3] && (c[8] || c[9])) begin e = E_VIRT; tag = "R6"; end
      else if (c[2] && route_both) begin e = c[13] ? E_UNDEF : E_T3; tag = "R6"; end
      else                        begin e = E_PHYS; tag = "R6"; end
    end else begin
      if (!c[5])                  begin e = E_T2; tag = "R7"; end
      else if (c[2] && route_both) begin e = c[13] ? E_UNDEF : E_T3; tag = "R7"; end
      else                        begin e = E_PHYS; tag = "R7"; end
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    req_valid = 1'b0; req_enc = '0; cur_level = 2'd1; ctl = '1;
    #2;
    check("R1 idle", {verdict, trap_class}, 12'h000);
  endtask

  task automatic t_valid_low();
    @(negedge clk);
    req_valid = 1'b0; req_enc = GOOD_ENC; cur_level = 2'd3; ctl = '0;
    #2;
    check("R1 valid low", {verdict, trap_class}, 12'h000);
  endtask

  task automatic t_enc_miss();
    for (int b = 0; b < 16; b++) begin
      @(negedge clk);
      req_valid = 1'b1; req_enc = GOOD_ENC ^ (16'h1 << b); cur_level = 2'd0; ctl = '0;
      #2;
      check($sformatf("R1 enc bit %0d", b), {verdict, trap_class}, 12'h000);
    end
  endtask

  task automatic t_sweep(input logic [1:0] lv);
    for (int k = 0; k < 16384; k++) begin
      logic [5:0] e;
      string tag;
      @(negedge clk);
      req_valid = 1'b1; req_enc = GOOD_ENC; cur_level = lv; ctl = 14'(k);
      reference(lv, 14'(k), e, tag);
      #2;
      // R2 one-hot and R9 class are covered by the combined compare.
      check($sformatf("%s R2 R9 level %0d ctl %h", tag, lv, k),
            {verdict, trap_class}, {e, (|e[4:2]) ? 6'h18 : 6'h00});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      finish_run();
    end
  end

  initial begin
    req_valid = 1'b0; req_enc = '0; cur_level = '0; ctl = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_valid_low();
    t_enc_miss();
    t_sweep(2'd0);
    t_sweep(2'd1);
    t_sweep(2'd2);
    t_sweep(2'd3);
    finish_run();
  end
endmodule